// File: doc/BRIEF.md
# Double-Buffered Output Handshake Port

This block is a byte-wide output port with a two-deep data pipeline: a holding stage and a pin stage. The bus side pushes bytes in with a one-cycle write strobe. A peripheral takes the byte on the pins by raising an acknowledge line, and the next held byte then drops into the pin stage at once. A second handshake line can be programmed into one of five behaviours: an edge-sensitive input with its own sticky flag, a constant low output, a constant high output, an interlocked data-ready output, or a data-ready pulse of bounded length.

Status outputs report buffer space, under one of two selectable meanings, a sticky flag for the handshake edge input, and a sticky overrun flag for writes that arrive when no stage has room. A per-bit direction mask drives the output enables. Bits marked as inputs still travel through the pipeline, but their drivers stay off. The acknowledge and handshake inputs come from outside the clock domain and are synchronized before use.

Top module: `dbuf_out_port`

## Requirements
- R1: After reset, port_data is 0, hs_out is 0, space_flag is 1 with space_sel=0, and overrun_flag and edge_flag are 0.
- R2: A byte written while both stages are empty appears on port_data in the cycle after the write strobe.
- R3: A byte written while the pin stage is full waits in the holding stage. It moves to port_data in the cycle after the acknowledge is taken, which is three clock edges after ack_in rises.
- R4: A write that arrives while both stages are full and no acknowledge is taken is dropped and sets overrun_flag. A one-cycle pulse on clr_overrun clears the flag.
- R5: With space_sel=0, space_flag is 0 only while both stages hold data.
- R6: With space_sel=1, space_flag is 1 only while both stages are empty.
- R7: With hs_mode=3 (interlocked), hs_out rises two clock edges after the pin stage loads. It stays high until a synchronized acknowledge edge is detected, and it goes low in that same cycle.
- R8: In interlocked mode, an acknowledge edge while hs_out is low changes neither port_data nor space_flag.
- R9: With hs_mode=4 (pulsed), hs_out rises with the R7 timing and stays high for exactly 4 cycles. An acknowledge edge during the pulse ends it in the cycle the edge is detected.
- R10: In modes 3 and 4, hs_out is held low while hs_enable is 0.
- R11: With hs_mode=0 (edge input), hs_oe is 0. A rising edge on hs_pin_in sets edge_flag three edges later. clr_edge_flag or hs_enable=0 clears the flag, and in every other mode the flag reads 0.
- R12: hs_mode=1 drives hs_out to a constant 0 and hs_mode=2 drives it to a constant 1. In both modes hs_oe is 1 and an acknowledge edge frees the pin stage without any handshake gating.
- R13: port_oe equals dir_mask bit for bit, and port_data carries the latched byte on every bit whatever the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to write |
| clr_overrun | input | 1 | Write-one clear of overrun_flag |
| clr_edge_flag | input | 1 | Write-one clear of edge_flag |
| hs_mode | input | 3 | Handshake line mode: 0 edge input, 1 low, 2 high, 3 interlocked, 4 pulsed |
| space_sel | input | 1 | 0: flag means some space; 1: flag means all empty |
| hs_enable | input | 1 | Handshake enable |
| dir_mask | input | 8 | Per-bit output direction (1 = drive) |
| ack_in | input | 1 | Asynchronous acknowledge from the peripheral |
| hs_pin_in | input | 1 | Asynchronous handshake line input (edge mode) |
| port_data | output | 8 | Pin stage contents |
| port_oe | output | 8 | Per-bit output enable |
| hs_out | output | 1 | Handshake line output level |
| hs_oe | output | 1 | Handshake line output enable |
| space_flag | output | 1 | Buffer space status |
| edge_flag | output | 1 | Sticky handshake-edge status |
| overrun_flag | output | 1 | Sticky dropped-write status |

## Verification
The bench goes after the cycle in which the interlocked output drops: a design that negates it one cycle late would hand the peripheral a stale ready. It fires acknowledges while the ready line is low and expects the data and space flag to stay put. A design that lets such edges through would skip bytes. It cuts a pulse short and also lets one run to its natural end, which catches counters that are off by one or ignore the acknowledge. It writes into a full pipeline, and a design that overwrites the held byte instead of dropping the write shows the wrong byte after the next acknowledge.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

    typedef enum logic [2:0] {
        HS_EDGE_IN   = 3'd0,
        HS_FIX_LO    = 3'd1,
        HS_FIX_HI    = 3'd2,
        HS_INTERLOCK = 3'd3,
        HS_PULSE     = 3'd4
    } hs_mode_e;

    typedef struct packed {
        logic il_full;
        logic fl_full;
    } occ_t;

    function automatic logic is_handshake(hs_mode_e m);
        return (m == HS_INTERLOCK) || (m == HS_PULSE);
    endfunction

    function automatic logic space_status(occ_t o, logic all_empty_sel);
        if (all_empty_sel)
            return !o.il_full && !o.fl_full;
        else
            return !(o.il_full && o.fl_full);
    endfunction

endpackage

// File: rtl/dbp_sync.sv
module dbp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/dbp_latch_pipe.sv
module dbp_latch_pipe
    import dbp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             consume,
    input  logic             clr_overrun,
    output logic [WIDTH-1:0] fl_data,
    output occ_t             occ,
    output logic             fl_load,
    output logic             overrun
);
    logic [WIDTH-1:0] il_data;
    logic             fl_free;

    assign fl_free = !occ.fl_full || consume;
    assign fl_load = fl_free && (occ.il_full || wr_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            il_data <= '0;
            fl_data <= '0;
            occ     <= '0;
            overrun <= 1'b0;
        end else begin
            if (clr_overrun) overrun <= 1'b0;
            if (fl_free) begin
                if (occ.il_full) begin
                    fl_data     <= il_data;
                    occ.fl_full <= 1'b1;
                    if (wr_en) il_data     <= wr_data;
                    else       occ.il_full <= 1'b0;
                end else if (wr_en) begin
                    fl_data     <= wr_data;
                    occ.fl_full <= 1'b1;
                end else begin
                    occ.fl_full <= 1'b0;
                end
            end else if (wr_en) begin
                if (!occ.il_full) begin
                    il_data     <= wr_data;
                    occ.il_full <= 1'b1;
                end else begin
                    overrun <= 1'b1;
                end
            end
        end
    end

    // R4
    ovr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && occ.il_full && occ.fl_full && !consume) |=> (overrun && $stable(il_data)));

    // R3
    fl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (occ.fl_full && !consume) |=> $stable(fl_data));
endmodule

// File: rtl/dbp_hs_ctrl.sv
module dbp_hs_ctrl
    import dbp_pkg::*;
#(
    parameter int HS_DELAY  = 2,
    parameter int PULSE_LEN = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  hs_mode_e mode,
    input  logic     hs_enable,
    input  logic     ack_rise,
    input  logic     pin_rise,
    input  logic     clr_edge_flag,
    input  logic     fl_full,
    input  logic     fl_load,
    output logic     consume,
    output logic     hs_out,
    output logic     hs_oe,
    output logic     edge_flag
);
    localparam int DLY_W = $clog2(HS_DELAY + 1);
    localparam int PW    = $clog2(PULSE_LEN + 1);

    logic             hsk;
    logic             shown;
    logic [DLY_W-1:0] dly;
    logic [PW-1:0]    pcnt;

    assign hsk     = is_handshake(mode);
    assign consume = ack_rise && fl_full && (!hsk || shown);

    always_ff @(posedge clk) begin
        if (rst) begin
            shown <= 1'b0;
            dly   <= '0;
            pcnt  <= '0;
        end else if (fl_load || !hs_enable || !hsk) begin
            shown <= 1'b0;
            dly   <= DLY_W'(HS_DELAY - 1);
            pcnt  <= '0;
        end else if (consume) begin
            shown <= 1'b0;
            pcnt  <= '0;
        end else if (fl_full && !shown) begin
            if (dly == '0) begin
                shown <= 1'b1;
                pcnt  <= PW'(PULSE_LEN);
            end else begin
                dly <= dly - 1'b1;
            end
        end else if (shown && pcnt != '0) begin
            pcnt <= pcnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !hs_enable || mode != HS_EDGE_IN) edge_flag <= 1'b0;
        else if (pin_rise)                          edge_flag <= 1'b1;
        else if (clr_edge_flag)                     edge_flag <= 1'b0;
    end

    always_comb begin
        case (mode)
            HS_FIX_HI:    hs_out = 1'b1;
            HS_INTERLOCK: hs_out = hs_enable && shown && !ack_rise;
            HS_PULSE:     hs_out = hs_enable && shown && (pcnt != '0) && !ack_rise;
            default:      hs_out = 1'b0;
        endcase
    end

    assign hs_oe = (mode != HS_EDGE_IN);

    logic [PW:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst || !(hs_out && mode == HS_PULSE)) hi_run <= '0;
        else if (hi_run <= (PW+1)'(PULSE_LEN))   hi_run <= hi_run + 1'b1;
    end

    // R7
    interlock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == HS_INTERLOCK && hs_enable && hs_out) |=>
            (hs_out || ack_rise || !hs_enable || mode != HS_INTERLOCK));

    // R9
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == HS_PULSE) |-> (hi_run <= (PW+1)'(PULSE_LEN)));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!hs_enable && hsk) |-> !hs_out);

    // R11
    edge_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != HS_EDGE_IN) |=> !edge_flag);
endmodule

// File: rtl/dbuf_out_port.sv
module dbuf_out_port
    import dbp_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HS_DELAY    = 2,
    parameter int PULSE_LEN   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             clr_overrun,
    input  logic             clr_edge_flag,
    input  logic [2:0]       hs_mode,
    input  logic             space_sel,
    input  logic             hs_enable,
    input  logic [WIDTH-1:0] dir_mask,
    input  logic             ack_in,
    input  logic             hs_pin_in,
    output logic [WIDTH-1:0] port_data,
    output logic [WIDTH-1:0] port_oe,
    output logic             hs_out,
    output logic             hs_oe,
    output logic             space_flag,
    output logic             edge_flag,
    output logic             overrun_flag
);
    hs_mode_e mode;
    occ_t     occ;
    logic     ack_rise, pin_rise, consume, fl_load;

    assign mode = hs_mode_e'(hs_mode);

    dbp_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk(clk), .rst(rst), .async_in(ack_in), .rise(ack_rise));

    dbp_sync #(.STAGES(SYNC_STAGES)) pin_sync_i (
        .clk(clk), .rst(rst), .async_in(hs_pin_in), .rise(pin_rise));

    dbp_latch_pipe #(.WIDTH(WIDTH)) pipe_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .consume(consume), .clr_overrun(clr_overrun),
        .fl_data(port_data), .occ(occ), .fl_load(fl_load),
        .overrun(overrun_flag));

    dbp_hs_ctrl #(.HS_DELAY(HS_DELAY), .PULSE_LEN(PULSE_LEN)) hs_i (
        .clk(clk), .rst(rst), .mode(mode), .hs_enable(hs_enable),
        .ack_rise(ack_rise), .pin_rise(pin_rise),
        .clr_edge_flag(clr_edge_flag), .fl_full(occ.fl_full),
        .fl_load(fl_load), .consume(consume), .hs_out(hs_out),
        .hs_oe(hs_oe), .edge_flag(edge_flag));

    assign space_flag = space_status(occ, space_sel);
    assign port_oe    = dir_mask;

    // R5
    space_any_chk: assert property (@(posedge clk) disable iff (rst)
        (!space_sel && !space_flag) |-> (occ.il_full && occ.fl_full));
endmodule

// File: tb/dbuf_out_port_tb_top.sv
module dbuf_out_port_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, clr_overrun, clr_edge_flag, space_sel, hs_enable;
    logic       ack_in, hs_pin_in;
    logic [7:0] wr_data, dir_mask, port_data, port_oe;
    logic [2:0] hs_mode;
    logic       hs_out, hs_oe, space_flag, edge_flag, overrun_flag;
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    always #5 clk = ~clk;

    dbuf_out_port dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .clr_overrun(clr_overrun), .clr_edge_flag(clr_edge_flag),
        .hs_mode(hs_mode), .space_sel(space_sel), .hs_enable(hs_enable),
        .dir_mask(dir_mask), .ack_in(ack_in), .hs_pin_in(hs_pin_in),
        .port_data(port_data), .port_oe(port_oe), .hs_out(hs_out),
        .hs_oe(hs_oe), .space_flag(space_flag), .edge_flag(edge_flag),
        .overrun_flag(overrun_flag));

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic full_ack();
        ack_in = 1'b1; step(3);
        ack_in = 1'b0; step(3);
    endtask

    task automatic t_reset();
        check("R1 data", port_data, 8'h00);
        check("R1 hs", hs_out, 1'b0);
        check("R1 space", space_flag, 1'b1);
        check("R1 ovr", overrun_flag, 1'b0);
        check("R1 edge", edge_flag, 1'b0);
    endtask

    task automatic t_interlock();
        hs_mode = 3'd3; space_sel = 1'b0; hs_enable = 1'b1;
        wr(8'hA5);
        check("R2 data", port_data, 8'hA5);
        check("R7 hs low at load", hs_out, 1'b0);
        step(1); check("R7 hs low +1", hs_out, 1'b0);
        step(1); check("R7 hs high +2", hs_out, 1'b1);
        wr(8'h3C);
        check("R3 still first byte", port_data, 8'hA5);
        check("R5 both full", space_flag, 1'b0);
        step(3); check("R7 hold", hs_out, 1'b1);
        ack_in = 1'b1;
        step(1); check("R7 before edge", hs_out, 1'b1);
        step(1); check("R7 drop on edge", hs_out, 1'b0);
        check("R3 not yet moved", port_data, 8'hA5);
        step(1); check("R3 moved", port_data, 8'h3C);
        check("R5 space back", space_flag, 1'b1);
        ack_in = 1'b0;
        step(1); check("R7 relaunch low", hs_out, 1'b0);
        step(1); check("R7 relaunch high", hs_out, 1'b1);
        hs_enable = 1'b0;
        step(1); check("R10 held low", hs_out, 1'b0);
        full_ack();
        check("R8 data kept", port_data, 8'h3C);
        check("R8 space kept", space_flag, 1'b1);
        hs_enable = 1'b1;
        step(2); check("R7 after enable", hs_out, 1'b1);
        full_ack();
        check("R7 consumed low", hs_out, 1'b0);
    endtask

    task automatic t_fixed_overrun();
        hs_mode = 3'd1;
        step(1);
        check("R12 low", hs_out, 1'b0);
        check("R12 oe", hs_oe, 1'b1);
        check("R11 flag zero", edge_flag, 1'b0);
        wr(8'h11); wr(8'h22); wr(8'h33);
        check("R4 overrun set", overrun_flag, 1'b1);
        check("R4 data", port_data, 8'h11);
        clr_overrun = 1'b1; step(1); clr_overrun = 1'b0;
        check("R4 cleared", overrun_flag, 1'b0);
        full_ack();
        check("R12 ack frees stage", port_data, 8'h22);
        full_ack();
        check("R4 dropped byte absent", port_data, 8'h22);
        hs_mode = 3'd2; step(1);
        check("R12 high", hs_out, 1'b1);
    endtask

    task automatic t_space_empty();
        hs_mode = 3'd1; space_sel = 1'b1; step(1);
        check("R6 empty", space_flag, 1'b1);
        wr(8'h44);
        check("R6 one held", space_flag, 1'b0);
        full_ack();
        check("R6 empty again", space_flag, 1'b1);
        space_sel = 1'b0;
    endtask

    task automatic t_pulse();
        hs_mode = 3'd4; hs_enable = 1'b1;
        wr(8'h5A);
        step(1); check("R9 low +1", hs_out, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(1); check("R9 pulse high", hs_out, 1'b1);
        end
        step(1); check("R9 pulse end", hs_out, 1'b0);
        full_ack();
        wr(8'h6B);
        step(2); check("R9 second pulse", hs_out, 1'b1);
        ack_in = 1'b1;
        step(1); check("R9 still high", hs_out, 1'b1);
        step(1); check("R9 cut short", hs_out, 1'b0);
        step(1); ack_in = 1'b0; step(3);
        check("R9 stays low", hs_out, 1'b0);
    endtask

    task automatic t_edge();
        hs_mode = 3'd0; hs_enable = 1'b1; step(1);
        check("R11 oe off", hs_oe, 1'b0);
        hs_pin_in = 1'b1;
        step(2); check("R11 not yet", edge_flag, 1'b0);
        step(1); check("R11 set", edge_flag, 1'b1);
        clr_edge_flag = 1'b1; step(1); clr_edge_flag = 1'b0;
        check("R11 cleared", edge_flag, 1'b0);
        hs_pin_in = 1'b0; step(3);
        hs_pin_in = 1'b1; step(3);
        check("R11 set again", edge_flag, 1'b1);
        hs_enable = 1'b0; step(1);
        check("R11 enable clear", edge_flag, 1'b0);
        hs_pin_in = 1'b0;
    endtask

    task automatic t_dir();
        hs_mode = 3'd1; dir_mask = 8'hF0;
        wr(8'h0F);
        check("R13 data", port_data, 8'h0F);
        check("R13 oe", port_oe, 8'hF0);
        dir_mask = 8'h0F; step(1);
        check("R13 oe swap", port_oe, 8'h0F);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; clr_overrun = 1'b0;
        clr_edge_flag = 1'b0; hs_mode = 3'd3; space_sel = 1'b0;
        hs_enable = 1'b1; dir_mask = 8'hFF; ack_in = 1'b0; hs_pin_in = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_interlock();
        t_fixed_overrun();
        t_space_empty();
        t_pulse();
        t_edge();
        t_dir();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule